// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Mask

This unit sits beside a processor's fetch stage. It holds a 32-bit pending register and a 32-bit enable register, both reached through a small control-register port. Four external request lines set fixed pending bits on their rising edges. Software clears pending bits by writing ones to them. Bit 0 of the enable register acts as the global interrupt enable.

At every instruction boundary the unit decides whether to take an interrupt. It considers an interrupt only while the global enable is set. The candidates are sources 1 to 31 that are both pending and enabled, and the lowest number wins. When it takes one, the unit captures the exception PC and the interrupted PC and clears the global enable. It then reads the handler address from a vector table in memory through a request/valid read port. While that read is outstanding it holds `busy_o` high so that fetch stalls. It ends the sequence with a one-cycle redirect that carries the new PC.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the pending and enable registers read 0, and `busy_o`, `mem_req_o` and `redirect_valid_o` are low.
- R2: A read at control address 0x4 returns the pending register and a read at 0x6 returns the enable register. Any other address reads 0.
- R3: A write to address 0x6 replaces all 32 enable bits.
- R4: A write to address 0x4 clears each pending bit whose data bit is 1 and leaves every other pending bit unchanged.
- R5: A rising edge on `ext_irq_i[0]`, `[1]`, `[2]` or `[3]` sets pending bit 11, 12, 29 or 30 in turn, visible on the next cycle. A line held high does not set its bit again. When an edge and a clear hit the same bit in one cycle, the edge wins.
- R6: No interrupt is taken while enable bit 0 is 0. Pending bit 0 is never a source.
- R7: Among the sources that are both pending and enabled, the lowest-numbered source i wins. The vector read address is 0x01010180 + 4*i.
- R8: On a take, `epc_o` becomes `fetch_pc_i` with bits [1:0] replaced by {0, global enable}, which gives binary 01. `eip_o` becomes `pc_i`.
- R9: A take clears enable bit 0 and keeps the other enable bits. A control write to the enable register in the same cycle loses bit 0 to the take.
- R10: From the cycle after a take, `busy_o` and `mem_req_o` stay high with a stable address until `mem_rvalid_i`. Inputs seen while busy start no new take.
- R11: The cycle after `mem_rvalid_i`, `redirect_valid_o` is high for exactly one cycle with `new_pc_o` equal to the returned data. `busy_o` then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cr_we_i | input | 1 | Control-register write strobe |
| cr_addr_i | input | 16 | Control-register address |
| cr_wdata_i | input | 32 | Control-register write data |
| cr_rdata_o | output | 32 | Control-register read data (combinational) |
| ext_irq_i | input | 4 | External interrupt request lines |
| boundary_i | input | 1 | Instruction boundary: the decision point before a fetch |
| pc_i | input | 32 | Current PC |
| fetch_pc_i | input | 32 | Next fetch PC |
| mem_req_o | output | 1 | Vector read request |
| mem_addr_o | output | 32 | Vector read address |
| mem_rvalid_i | input | 1 | Vector read data valid |
| mem_rdata_i | input | 32 | Vector read data |
| busy_o | output | 1 | Sequence in progress; fetch must stall |
| redirect_valid_o | output | 1 | One-cycle fetch redirect |
| new_pc_o | output | 32 | Handler address |
| epc_o | output | 32 | Captured exception PC with saved global enable |
| eip_o | output | 32 | Captured interrupted PC |

## Verification
A corrupted pending or enable bit shows on the next control read. It also shows on the first boundary that follows, as a wrong vector address or a missing or spurious `busy_o`, one cycle after the boundary. A sequencer stuck outside idle shows as `busy_o` staying high or `redirect_valid_o` lasting more than one cycle. A wrongly captured index shows as a wrong `mem_addr_o` while the request is out. An edge detector that sets on level shows after the first write-one-to-clear, because the cleared bit reappears at once.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int unsigned NUM_EXT = 4;
  localparam int unsigned EXT_POS [NUM_EXT] = '{11, 12, 29, 30};
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} seq_st_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_vc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_i,
  input  logic               clr_we_i,
  input  logic [N_SRC-1:0]   clr_mask_i,
  output logic [N_SRC-1:0]   pend_o
);
  logic [NUM_EXT-1:0] ext_q;
  logic [NUM_EXT-1:0] rise;
  logic [N_SRC-1:0]   set_vec;
  logic [N_SRC-1:0]   pend_q;

  assign rise = ext_i & ~ext_q;

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < NUM_EXT; k++) set_vec[EXT_POS[k]] = rise[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= '0;
      pend_q <= '0;
    end else begin
      ext_q  <= ext_i;
      // set beats clear on the same bit
      pend_q <= (pend_q & ~(clr_we_i ? clr_mask_i : '0)) | set_vec;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);
  // source 0 is the global mask, never a candidate
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 1; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_vc_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned IW       = 5,
  parameter logic [AW-1:0] VEC_BASE = 32'h0101_0180
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [IW-1:0] idx_i,
  input  logic          gie_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          idle_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          redirect_o,
  output logic [AW-1:0] new_pc_o,
  output logic [AW-1:0] epc_o,
  output logic [AW-1:0] eip_o
);
  seq_st_e       st_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] epc_q, eip_q, npc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      epc_q <= '0;
      eip_q <= '0;
      npc_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_i) begin
          epc_q <= {fetch_pc_i[AW-1:2], 1'b0, gie_i};
          eip_q <= pc_i;
          idx_q <= idx_i;
          st_q  <= ST_FETCH;
        end
        ST_FETCH: if (mem_rvalid_i) begin
          npc_q <= mem_rdata_i;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign mem_req_o  = (st_q == ST_FETCH);
  assign mem_addr_o = VEC_BASE + {{(AW-IW-2){1'b0}}, idx_q, 2'b00};
  assign redirect_o = (st_q == ST_DONE);
  assign new_pc_o   = npc_q;
  assign epc_o      = epc_q;
  assign eip_o      = eip_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vc_pkg::*;
#(
  parameter int unsigned CR_AW   = 16,
  parameter int unsigned DW      = 32,
  parameter logic [CR_AW-1:0] PEND_ADDR = 16'h0004,
  parameter logic [CR_AW-1:0] EN_ADDR   = 16'h0006,
  parameter logic [DW-1:0]    VEC_BASE  = 32'h0101_0180,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cr_we_i,
  input  logic [CR_AW-1:0]   cr_addr_i,
  input  logic [DW-1:0]      cr_wdata_i,
  output logic [DW-1:0]      cr_rdata_o,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic               boundary_i,
  input  logic [DW-1:0]      pc_i,
  input  logic [DW-1:0]      fetch_pc_i,
  output logic               mem_req_o,
  output logic [DW-1:0]      mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               busy_o,
  output logic               redirect_valid_o,
  output logic [DW-1:0]      new_pc_o,
  output logic [DW-1:0]      epc_o,
  output logic [DW-1:0]      eip_o
);
  logic [DW-1:0] pend_q, en_q;
  logic          hit, idle, take;
  logic [IW-1:0] win_idx;

  irq_pend_reg #(.N_SRC(DW)) u_pend (
    .clk_i, .rst_ni,
    .ext_i      (ext_irq_i),
    .clr_we_i   (cr_we_i && cr_addr_i == PEND_ADDR),
    .clr_mask_i (cr_wdata_i),
    .pend_o     (pend_q)
  );

  irq_pick #(.N_SRC(DW)) u_pick (
    .req_i (pend_q & en_q),
    .hit_o (hit),
    .idx_o (win_idx)
  );

  assign take = idle && boundary_i && en_q[0] && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else begin
      if (cr_we_i && cr_addr_i == EN_ADDR) en_q <= cr_wdata_i;
      if (take) en_q[0] <= 1'b0;
    end
  end

  irq_seq #(.AW(DW), .IW(IW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk_i, .rst_ni,
    .take_i       (take),
    .idx_i        (win_idx),
    .gie_i        (en_q[0]),
    .pc_i, .fetch_pc_i,
    .mem_rvalid_i, .mem_rdata_i,
    .idle_o       (idle),
    .mem_req_o, .mem_addr_o,
    .redirect_o   (redirect_valid_o),
    .new_pc_o, .epc_o, .eip_o
  );

  assign busy_o = !idle;

  always_comb begin
    if (cr_addr_i == PEND_ADDR)    cr_rdata_o = pend_q;
    else if (cr_addr_i == EN_ADDR) cr_rdata_o = en_q;
    else                           cr_rdata_o = '0;
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_vc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EXT-1:0] ext_irq_i,
  input logic [31:0]        pend,
  input logic [31:0]        en,
  input logic               busy_o,
  input logic               mem_req_o,
  input logic [31:0]        mem_addr_o,
  input logic               mem_rvalid_i,
  input logic [31:0]        mem_rdata_i,
  input logic               redirect_valid_o,
  input logic [31:0]        new_pc_o,
  input logic [31:0]        epc_o
);
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    AST_EXT_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ext_irq_i[k]) |=> pend[EXT_POS[k]]); // R5
  end

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !en[0]); // R9
  AST_EPC_SAVES_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> epc_o[1:0] == 2'b01); // R8
  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R7
  AST_REQ_UNDER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R10
  AST_REQ_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> $stable(mem_addr_o)); // R10
  AST_REDIR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> !redirect_valid_o); // R11
  AST_REDIR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> $past(mem_rvalid_i) && new_pc_o == $past(mem_rdata_i)); // R11
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk_i, .rst_ni, .ext_irq_i,
  .pend (pend_q),
  .en   (en_q),
  .busy_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
  .redirect_valid_o, .new_pc_o, .epc_o
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        cr_we = 0;
  logic [15:0] cr_addr = 0;
  logic [31:0] cr_wdata = 0, cr_rdata;
  logic [3:0]  ext = 0;
  logic        boundary = 0;
  logic [31:0] pc = 0, fpc = 0;
  logic        mem_req, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        busy, redir;
  logic [31:0] new_pc, epc, eip;

  int checks = 0, errors = 0;
  bit done = 0;
  int xmap [4] = '{11, 12, 29, 30};
  logic [31:0] exp_pend = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cr_we_i(cr_we), .cr_addr_i(cr_addr), .cr_wdata_i(cr_wdata), .cr_rdata_o(cr_rdata),
    .ext_irq_i(ext), .boundary_i(boundary), .pc_i(pc), .fetch_pc_i(fpc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .redirect_valid_o(redir), .new_pc_o(new_pc),
    .epc_o(epc), .eip_o(eip)
  );

  function automatic logic [31:0] vec_addr(int i);
    return 32'h0101_0180 + 32'(i) * 4;
  endfunction

  function automatic int winner(logic [31:0] p, logic [31:0] e);
    for (int i = 1; i < 32; i++) if (p[i] && e[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cr_wr(logic [15:0] a, logic [31:0] d);
    cr_we = 1; cr_addr = a; cr_wdata = d;
    @(negedge clk);
    cr_we = 0;
  endtask

  task automatic cr_rd(logic [15:0] a, output logic [31:0] d);
    cr_addr = a; #1; d = cr_rdata;
  endtask

  task automatic pulse_ext(logic [3:0] m);
    ext = m;
    @(negedge clk);
    ext = 0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) if (m[k]) exp_pend[xmap[k]] = 1'b1;
  endtask

  task automatic do_take(int idx, int dly, logic [31:0] en_before);
    logic [31:0] p, f, d, r;
    p = $urandom; f = $urandom; d = $urandom;
    pc = p; fpc = f; boundary = 1;
    @(negedge clk);
    boundary = 0;
    chk(busy && mem_req, "R10", {30'b0, busy, mem_req}, 32'h3);
    chk(mem_addr == vec_addr(idx), "R7", mem_addr, vec_addr(idx));
    chk(epc == {f[31:2], 2'b01}, "R8", epc, {f[31:2], 2'b01});
    chk(eip == p, "R8", eip, p);
    cr_rd(16'h6, r);
    chk(r == (en_before & ~32'h1), "R9", r, en_before & ~32'h1);
    for (int c = 0; c < dly; c++) begin
      @(negedge clk);
      chk(mem_req && !redir && mem_addr == vec_addr(idx), "R10", mem_addr, vec_addr(idx));
    end
    mem_rvalid = 1; mem_rdata = d;
    @(negedge clk);
    mem_rvalid = 0;
    chk(redir && new_pc == d, "R11", new_pc, d);
    @(negedge clk);
    chk(!redir && !busy, "R11", {30'b0, redir, busy}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d, m, en;
    int w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !mem_req && !redir, "R1", {29'b0, busy, mem_req, redir}, 0);
    cr_rd(16'h4, r); chk(r == 0, "R1", r, 0);
    cr_rd(16'h6, r); chk(r == 0, "R1", r, 0);

    // R3 / R2 enable write and readback
    for (int i = 0; i < 10; i++) begin
      d = $urandom & 32'hFFFF_FFFE;
      cr_wr(16'h6, d);
      cr_rd(16'h6, r); chk(r == d, "R3", r, d);
      cr_rd(16'h5, r); chk(r == 0, "R2", r, 0);
    end
    cr_wr(16'h6, 0);

    // R5 each line maps to its bit
    for (int k = 0; k < 4; k++) begin
      pulse_ext(4'(1 << k));
      cr_rd(16'h4, r); chk(r == exp_pend, "R5", r, exp_pend);
    end

    // R4 random W1C
    for (int i = 0; i < 15; i++) begin
      pulse_ext(4'($urandom));
      m = $urandom;
      cr_wr(16'h4, m);
      exp_pend &= ~m;
      cr_rd(16'h4, r); chk(r == exp_pend, "R4", r, exp_pend);
    end

    // R5 level held does not re-set
    cr_wr(16'h4, 32'hFFFF_FFFF); exp_pend = 0;
    ext[0] = 1;
    repeat (2) @(negedge clk);
    cr_wr(16'h4, 32'h800);
    repeat (2) @(negedge clk);
    cr_rd(16'h4, r); chk(r[11] == 0, "R5", r, 0);
    ext[0] = 0;
    @(negedge clk);
    // R5 set beats clear in the same cycle
    ext[1] = 1; cr_we = 1; cr_addr = 16'h4; cr_wdata = 32'h1000;
    @(negedge clk);
    cr_we = 0; ext[1] = 0;
    cr_rd(16'h4, r); chk(r == 32'h1000, "R5", r, 32'h1000);
    exp_pend = 32'h1000;

    // R6 no take without global enable
    cr_wr(16'h6, 32'h1000);
    boundary = 1; @(negedge clk); boundary = 0;
    chk(!busy && !mem_req, "R6", {30'b0, busy, mem_req}, 0);

    // R7/R8/R9/R10/R11 random takes
    pulse_ext(4'hF);
    for (int i = 0; i < 10; i++) begin
      m = 32'h6000_1800 & $urandom;
      if (m == 0) m = 32'h2000_0000;
      en = m | 32'h1;
      cr_wr(16'h6, en);
      w = winner(exp_pend, en);
      do_take(w, int'($urandom % 4), en);
    end

    // R9: take cleared gie, so boundary alone does nothing
    boundary = 1; @(negedge clk); boundary = 0;
    chk(!busy, "R9", {31'b0, busy}, 0);

    // R10 no new decision while busy
    en = 32'h2000_1801;
    cr_wr(16'h6, en);
    pc = 32'h100; fpc = 32'h204; boundary = 1;
    @(negedge clk);
    cr_wr(16'h6, 32'h0000_0801);
    pc = 32'h999; fpc = 32'h888;
    repeat (2) @(negedge clk);
    chk(mem_addr == vec_addr(11) && epc == 32'h205 && eip == 32'h100, "R10", epc, 32'h205);
    boundary = 0;
    mem_rvalid = 1; mem_rdata = 32'hCAFE_0000;
    @(negedge clk); mem_rvalid = 0;
    chk(redir && new_pc == 32'hCAFE_0000, "R11", new_pc, 32'hCAFE_0000);
    @(negedge clk);
    cr_wr(16'h6, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule